// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 64-bit byte address from up to three parts: a 32-bit signed displacement, an optional base register value and an optional index register value that is scaled by 1, 2, 4 or 8. Each register operand has its own use flag. A cleared flag removes that operand from the sum. The scale is applied as a left shift of the index, and the three terms are added modulo 2^64.

The block makes no memory access, so the same result serves as plain shift-and-add arithmetic whose 64-bit value goes to a destination register. With base and index both set to x, scale code 2 and displacement 7, the result is 5x+7. A parameter selects whether the sum is registered (default) or presented combinationally.

Top module: `ea_gen`

## Requirements
- R1: With OUT_REG=1, `addr_o` equals sext64(`disp_i`) + (`base_use_i` ? `base_i` : 0) + (`idx_use_i` ? `idx_i` × 2^`scale_i` : 0), taken from the inputs present at the previous rising clock edge.
- R2: `scale_i` codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 respectively. Bits of the index shifted beyond bit 63 are lost.
- R3: When `base_use_i` is 0, the value on `base_i` has no effect on `addr_o`.
- R4: When `idx_use_i` is 0, the values on `idx_i` and `scale_i` have no effect on `addr_o`.
- R5: `disp_i` is a two's-complement value. Bit 31 is copied into bits 63..32 before the addition, so 0xFFFFFFF0 acts as -16.
- R6: The sum wraps modulo 2^64 and no carry or overflow indication is produced.
- R7: With OUT_REG=1, `addr_o` holds its value between rising edges when the inputs change, and it shows a new result one cycle after the inputs are sampled.
- R8: While `rst` is high at a rising edge, `addr_o` becomes 0 whatever the operand inputs carry.
- R9: With base = index = x, scale code 2 and displacement 7, `addr_o` equals 5x+7 (shift-and-add use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| disp_i | input | 32 | Signed displacement |
| base_i | input | 64 | Base register value |
| base_use_i | input | 1 | 1 = add the base value |
| idx_i | input | 64 | Index register value |
| idx_use_i | input | 1 | 1 = add the scaled index |
| scale_i | input | 2 | Index shift amount code (0..3) |
| addr_o | output | 64 | Effective address / arithmetic result |

## Verification
The only state in the block is the output register, so any error in the shift selection, operand masking or sign extension shows up on `addr_o` in the cycle right after the faulty input vector. A wrong scale decode shows as a result off by a power of two. A missing sign extension appears only when the displacement is negative, and it corrupts the upper 32 bits. A mask fault shows only when a disabled operand carries non-zero data. For these reasons the stimulus pairs every cleared use flag with all-ones data and includes negative displacements and carries out of bit 63.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int ADDR_W  = 64;
    localparam int DISP_W  = 32;
    localparam int SCALE_W = 2;
    localparam int NSCALE  = 1 << SCALE_W;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [DISP_W-1:0]  disp_t;

    typedef enum logic [SCALE_W-1:0] {
        SC_X1 = 2'd0,
        SC_X2 = 2'd1,
        SC_X4 = 2'd2,
        SC_X8 = 2'd3
    } scale_e;

    typedef struct packed {
        disp_t  disp;
        addr_t  base;
        logic   base_use;
        addr_t  idx;
        logic   idx_use;
        scale_e scale;
    } ea_req_t;

    typedef struct packed {
        addr_t disp_term;
        addr_t base_term;
        addr_t idx_term;
    } ea_terms_t;

    function automatic addr_t gate_operand(input addr_t v, input logic use_it);
        return use_it ? v : '0;
    endfunction
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  disp,
    output logic [OUT_W-1:0] disp_wide
);
    localparam int FILL_W = OUT_W - IN_W;

    // replicate the sign bit into the upper part
    assign disp_wide = {{FILL_W{disp[IN_W-1]}}, disp};
endmodule

// File: rtl/ea_idx_scaler.sv
module ea_idx_scaler #(
    parameter int W       = 64,
    parameter int SCALE_W = 2
) (
    input  logic [W-1:0]       idx,
    input  logic               idx_use,
    input  logic [SCALE_W-1:0] scale,
    output logic [W-1:0]       idx_scaled
);
    localparam int NSH = 1 << SCALE_W;

    logic [W-1:0] cand [NSH];
    logic [W-1:0] gated;

    assign gated = idx_use ? idx : '0;

    // one pre-shifted copy per scale code, then a select
    for (genvar g = 0; g < NSH; g++) begin : g_shift
        assign cand[g] = gated << g;
    end

    assign idx_scaled = cand[scale];
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
    parameter int W    = 64,
    parameter int NOPS = 3
) (
    input  logic [NOPS-1:0][W-1:0] ops,
    output logic [W-1:0]           sum
);
    always_comb begin
        sum = '0;
        for (int k = 0; k < NOPS; k++) begin
            sum = sum + ops[k];   // modulo 2^W, carry discarded
        end
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic                base_use_i,
    input  logic [ADDR_W-1:0]   idx_i,
    input  logic                idx_use_i,
    input  logic [SCALE_W-1:0]  scale_i,
    output logic [ADDR_W-1:0]   addr_o
);
    localparam int NTERMS = 3;

    ea_req_t   req;
    ea_terms_t terms;
    addr_t     sum_c;
    logic [NTERMS-1:0][ADDR_W-1:0] op_vec;

    assign req.disp     = disp_i;
    assign req.base     = base_i;
    assign req.base_use = base_use_i;
    assign req.idx      = idx_i;
    assign req.idx_use  = idx_use_i;
    assign req.scale    = scale_e'(scale_i);

    ea_disp_ext #(.IN_W(DISP_W), .OUT_W(ADDR_W)) u_ext (
        .disp      (req.disp),
        .disp_wide (terms.disp_term)
    );

    assign terms.base_term = gate_operand(req.base, req.base_use);

    ea_idx_scaler #(.W(ADDR_W), .SCALE_W(SCALE_W)) u_scl (
        .idx        (req.idx),
        .idx_use    (req.idx_use),
        .scale      (req.scale),
        .idx_scaled (terms.idx_term)
    );

    assign op_vec[0] = terms.disp_term;
    assign op_vec[1] = terms.base_term;
    assign op_vec[2] = terms.idx_term;

    ea_adder #(.W(ADDR_W), .NOPS(NTERMS)) u_add (
        .ops (op_vec),
        .sum (sum_c)
    );

    if (OUT_REG) begin : g_reg
        addr_t addr_q;
        always_ff @(posedge clk) begin
            if (rst) addr_q <= '0;
            else     addr_q <= sum_c;
        end
        assign addr_o = addr_q;
    end else begin : g_comb
        logic unused_ck;
        assign unused_ck = clk ^ rst;
        assign addr_o    = sum_c;
    end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] disp_i,
    input logic [63:0] base_i,
    input logic        base_use_i,
    input logic [63:0] idx_i,
    input logic        idx_use_i,
    input logic [1:0]  scale_i,
    input logic [63:0] addr_o
);
    if (OUT_REG) begin : g_seq
        // R8: reset clears the result
        a_r8_reset_zero: assert property (@(posedge clk)
            rst |=> addr_o == 64'd0);

        // R1: full sum one cycle later
        a_r1_sum: assert property (@(posedge clk) disable iff (rst)
            !rst |=> addr_o == {{32{$past(disp_i[31])}}, $past(disp_i)}
                             + ($past(base_use_i) ? $past(base_i) : 64'd0)
                             + ($past(idx_use_i) ? ($past(idx_i) << $past(scale_i)) : 64'd0));

        // R3 / R4 / R5: with both operands off only the extended displacement remains
        a_r5_disp_only: assert property (@(posedge clk) disable iff (rst)
            (!base_use_i && !idx_use_i) |=> addr_o == {{32{$past(disp_i[31])}}, $past(disp_i)});

        // R2: pure index term with zero displacement and no base
        a_r2_idx_only: assert property (@(posedge clk) disable iff (rst)
            (!base_use_i && idx_use_i && disp_i == 32'd0) |=> addr_o == ($past(idx_i) << $past(scale_i)));

        // R7: unchanged inputs give an unchanged output
        a_r7_hold: assert property (@(posedge clk) disable iff (rst)
            ($stable(disp_i) && $stable(base_i) && $stable(base_use_i) && $stable(idx_i)
             && $stable(idx_use_i) && $stable(scale_i) && !$past(rst)) |=> $stable(addr_o));
    end else begin : g_cmb
        a_r1_sum_c: assert property (@(posedge clk) disable iff (rst)
            addr_o == {{32{disp_i[31]}}, disp_i}
                      + (base_use_i ? base_i : 64'd0)
                      + (idx_use_i ? (idx_i << scale_i) : 64'd0));
        a_r5_disp_only_c: assert property (@(posedge clk) disable iff (rst)
            (!base_use_i && !idx_use_i) |-> addr_o == {{32{disp_i[31]}}, disp_i});
        a_r2_idx_only_c: assert property (@(posedge clk) disable iff (rst)
            (!base_use_i && idx_use_i && disp_i == 32'd0) |-> addr_o == (idx_i << scale_i));
        a_r6_wrap_c: assert property (@(posedge clk) disable iff (rst)
            (!idx_use_i && base_use_i && disp_i == 32'd1 && base_i == '1) |-> addr_o == 64'd0);
    end
endmodule

bind ea_gen ea_gen_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_i     (disp_i),
    .base_i     (base_i),
    .base_use_i (base_use_i),
    .idx_i      (idx_i),
    .idx_use_i  (idx_use_i),
    .scale_i    (scale_i),
    .addr_o     (addr_o)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] disp_i = '0;
    logic [63:0] base_i = '0;
    logic        base_use_i = 1'b0;
    logic [63:0] idx_i = '0;
    logic        idx_use_i = 1'b0;
    logic [1:0]  scale_i = '0;
    logic [63:0] addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] q_exp[$];
    string       q_tag[$];
    logic [63:0] last_out = '0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    ea_gen uut (
        .clk(clk), .rst(rst), .disp_i(disp_i), .base_i(base_i), .base_use_i(base_use_i),
        .idx_i(idx_i), .idx_use_i(idx_use_i), .scale_i(scale_i), .addr_o(addr_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] d, input logic [63:0] b, input logic bu,
                                          input logic [63:0] x, input logic xu, input logic [1:0] s);
        longint dv;
        logic [63:0] mul;
        logic [63:0] r;
        dv = longint'($signed(d));
        case (s)
            2'd0: mul = 64'd1;
            2'd1: mul = 64'd2;
            2'd2: mul = 64'd4;
            default: mul = 64'd8;
        endcase
        r = 64'(dv);
        if (bu) r = r + b;
        if (xu) r = r + x * mul;
        return r;
    endfunction

    // one cycle: compare the previous vector's result, then drive a new one
    task automatic step(input logic [31:0] d, input logic [63:0] b, input logic bu,
                        input logic [63:0] x, input logic xu, input logic [1:0] s, input string tag);
        @(negedge clk);
        if (q_exp.size() > 0) check(q_tag.pop_front(), addr_o, q_exp.pop_front());
        last_out = addr_o;
        disp_i = d; base_i = b; base_use_i = bu; idx_i = x; idx_use_i = xu; scale_i = s;
        q_exp.push_back(model(d, b, bu, x, xu, s));
        q_tag.push_back(tag);
        #1;
        check("R7 hold before edge", addr_o, last_out);
    endtask

    function automatic logic [63:0] next_rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    initial begin
        // R8: busy operands during reset must not reach the output
        disp_i = 32'h1234_5678; base_i = '1; base_use_i = 1'b1;
        idx_i = 64'h55; idx_use_i = 1'b1; scale_i = 2'd3;
        repeat (3) @(negedge clk);
        check("R8 reset value", addr_o, 64'd0);
        rst = 1'b0;

        // R9: shift-and-add, 5x+7
        step(32'd7, 64'h1234, 1'b1, 64'h1234, 1'b1, 2'd2, "R9 5x+7");
        step(32'd7, 64'hFFFF_FFFF, 1'b1, 64'hFFFF_FFFF, 1'b1, 2'd2, "R9 5x+7 wide");
        // R2: each scale code
        for (int s = 0; s < 4; s++)
            step(32'd0, 64'd0, 1'b0, 64'h10, 1'b1, 2'(s), "R2 scale code");
        step(32'd0, 64'd0, 1'b0, 64'hF000_0000_0000_0001, 1'b1, 2'd3, "R2 bits lost above 63");
        // R3: disabled base with all-ones data
        step(32'd100, '1, 1'b0, 64'h8, 1'b1, 2'd1, "R3 base ignored");
        // R4: disabled index with all-ones data, every scale
        step(32'd5, 64'h1000, 1'b1, '1, 1'b0, 2'd3, "R4 index ignored");
        step(32'd5, 64'h1000, 1'b1, '1, 1'b0, 2'd0, "R4 scale ignored");
        // R5: negative displacement
        step(32'hFFFF_FFF0, 64'h100, 1'b1, 64'd0, 1'b0, 2'd0, "R5 disp -16");
        step(32'h8000_0000, 64'd0, 1'b0, 64'd0, 1'b0, 2'd0, "R5 most negative disp");
        step(32'h7FFF_FFFF, 64'd0, 1'b0, 64'd0, 1'b0, 2'd0, "R5 most positive disp");
        // R6: wrap past 2^64
        step(32'd1, '1, 1'b1, 64'd0, 1'b0, 2'd0, "R6 wrap to zero");
        step(32'hFFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 2'd0, "R6 wrap carry");
        // R7: repeated vector keeps output
        step(32'd3, 64'd9, 1'b1, 64'd2, 1'b1, 2'd1, "R7 first");
        step(32'd3, 64'd9, 1'b1, 64'd2, 1'b1, 2'd1, "R7 repeat");
        // R1: mixed random vectors
        for (int k = 0; k < 300; k++) begin
            logic [63:0] a, b2, c;
            a = next_rnd(); b2 = next_rnd(); c = next_rnd();
            step(a[31:0], b2, c[0], c, a[40], a[45:44], "R1 random sum");
        end
        @(negedge clk);
        if (q_exp.size() > 0) check(q_tag.pop_front(), addr_o, q_exp.pop_front());

        // R8: reset in mid-run clears the output
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run reset", addr_o, 64'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule